// File: doc/BRIEF.md
# Float to Extended-Precision Converter

This block moves binary floating-point operands between two compact memory formats and one wide three-word working layout. A 32-bit single word, or a double held in two 32-bit words, is widened into a 96-bit extended image. An extended image can also be narrowed back to single or double. Narrowing rounds the magnitude half-up and renormalizes when the rounding carries out of the kept mantissa.

The widening path makes the leading one explicit as the integer bit of a 64-bit mantissa. It rebiases the exponent into a 15-bit field. Zeros, denormals, infinities and NaNs are each mapped to the same class in the destination. Narrowing results that fall outside the destination's exponent range become signed zero or signed infinity.

Operands enter through a valid/ready handshake together with a two-bit format select. Results leave from a register stage through a second valid/ready handshake. With the output side ready, one conversion completes every cycle.

Top module: `fp_ext_converter`

## Requirements
- R1: An input is accepted on a clock edge where in_valid and in_ready are both high. out_valid is high in the cycle after an acceptance. in_ready equals (not out_valid) or out_ready. After reset, out_valid is low and in_ready is high.
- R2: While out_valid is high and out_ready is low, out_valid and all three output words hold their values.
- R3: in_fmt selects the conversion: 0 single to extended, 1 double to extended, 2 extended to single, 3 extended to double. Layouts are as follows. Single: sign bit 31, 8-bit exponent in bits 30:23 with bias 127, 23-bit fraction. Double: first word has sign bit 31, 11-bit exponent in bits 30:20 with bias 1023, and the top 20 fraction bits; the second word has the low 32 fraction bits. Extended: first word has sign bit 31, 15-bit exponent in bits 30:16 with bias 16383, and zeros in bits 15:0; the second and third words hold the 64-bit mantissa, most significant word first. Output words that a narrow result does not use are zero. When no rounding happens, a narrow mantissa is the top bits of the extended mantissa below its integer bit.
- R4: An input whose exponent and fraction (or mantissa) are all zero gives an all-zero result, so negative zero leaves as positive zero.
- R5: Widening a normal operand keeps the sign and adds 16256 (single) or 15360 (double) to the exponent. The mantissa is a one in bit 63 followed by the fraction left-aligned, with zeros below it.
- R6: Narrowing adds one at the first bit below the kept mantissa (bit 39 for single, bit 10 for double) and then truncates.
- R7: If that addition carries out of the kept mantissa, the mantissa shifts right by one and the exponent increases by one.
- R8: An all-ones source exponent gives an all-ones destination exponent with no rounding. When widening, the fraction is copied. When narrowing, the top fraction bits are kept, and the lowest kept bit is ORed with any nonzero dropped bit, so a NaN stays a NaN.
- R9: A zero exponent with a nonzero fraction, or a narrowed exponent of zero or below, gives a zero with the sign kept.
- R10: A narrowed exponent at or above the destination's all-ones value gives a signed infinity (all-ones exponent, zero fraction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be accepted |
| in_fmt | input | 2 | Conversion select |
| in_w0 | input | 32 | Operand word 0 |
| in_w1 | input | 32 | Operand word 1 |
| in_w2 | input | 32 | Operand word 2 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_w0 | output | 32 | Result word 0 |
| out_w1 | output | 32 | Result word 1 |
| out_w2 | output | 32 | Result word 2 |

## Verification
The block's only state is the output register and its valid flag. A wrong valid update shows on the next cycle as a missing, duplicated or lost result, or as in_ready disagreeing with the stall. A wrong conversion shows in the output words in the cycle right after acceptance, so a cycle-by-cycle comparison pins each fault to one operand. Directed operands reach rounding carry, the half-way bit, flush, saturation and NaN stickiness. Random operands with random back-pressure cover the rest.

// File: rtl/fp_ext_converter.sv
module fp_ext_converter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  in_fmt,
  input  logic [31:0] in_w0,
  input  logic [31:0] in_w1,
  input  logic [31:0] in_w2,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_w0,
  output logic [31:0] out_w1,
  output logic [31:0] out_w2
);
  localparam int XBIAS = 16383;
  localparam int SBIAS = 127;
  localparam int DBIAS = 1023;

  logic acc;
  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  // widening
  logic        sgn;
  logic [10:0] w_e;
  logic [51:0] w_f;
  logic        w_max;
  logic [14:0] w_x;
  assign sgn = in_w0[31];
  always_comb begin
    if (in_fmt[0]) begin
      w_e   = in_w0[30:20];
      w_f   = {in_w0[19:0], in_w1};
      w_max = &in_w0[30:20];
    end else begin
      w_e   = {3'b0, in_w0[30:23]};
      w_f   = {in_w0[22:0], 29'b0};
      w_max = &in_w0[30:23];
    end
  end
  assign w_x = w_max ? 15'h7fff
             : 15'(w_e) + (in_fmt[0] ? 15'(XBIAS - DBIAS) : 15'(XBIAS - SBIAS));

  // narrowing
  logic [14:0] x_e;
  logic [63:0] x_m;
  logic        unused_low;
  assign x_e = in_w0[30:16];
  assign x_m = {in_w1, in_w2};
  assign unused_low = ^in_w0[15:0];

  logic [24:0] s_sum;
  logic [53:0] d_sum;
  logic [17:0] s_ne, d_ne;
  logic [22:0] s_fr, s_nan;
  logic [51:0] d_fr, d_nan;
  logic        s_c, d_c, s_under, s_over, d_under, d_over;

  assign s_sum   = {1'b0, x_m[63:40]} + 25'(x_m[39]);
  assign s_c     = s_sum[24];
  assign s_fr    = s_c ? s_sum[23:1] : s_sum[22:0];
  assign s_ne    = 18'(x_e) - 18'(XBIAS - SBIAS) + 18'(s_c);
  assign s_under = s_ne[17] || s_ne == 18'd0;
  assign s_over  = !s_ne[17] && s_ne >= 18'd255;
  assign s_nan   = x_m[62:40] | {22'b0, |x_m[39:0]};

  assign d_sum   = {1'b0, x_m[63:11]} + 54'(x_m[10]);
  assign d_c     = d_sum[53];
  assign d_fr    = d_c ? d_sum[52:1] : d_sum[51:0];
  assign d_ne    = 18'(x_e) - 18'(XBIAS - DBIAS) + 18'(d_c);
  assign d_under = d_ne[17] || d_ne == 18'd0;
  assign d_over  = !d_ne[17] && d_ne >= 18'd2047;
  assign d_nan   = x_m[62:11] | {51'b0, |x_m[10:0]};

  logic [31:0] n0, n1, n2;
  always_comb begin
    n0 = 32'b0; n1 = 32'b0; n2 = 32'b0;
    if (!in_fmt[1]) begin
      if (w_e == 11'd0 && w_f == 52'd0) n0 = 32'b0;
      else if (w_e == 11'd0)            n0 = {sgn, 31'b0};
      else begin
        n0 = {sgn, w_x, 16'b0};
        n1 = {1'b1, w_f[51:21]};
        n2 = {w_f[20:0], 11'b0};
      end
    end else if (!in_fmt[0]) begin
      if (x_e == 15'd0 && x_m == 64'd0) n0 = 32'b0;
      else if (&x_e)                    n0 = {sgn, 8'hff, s_nan};
      else if (x_e == 15'd0 || s_under) n0 = {sgn, 31'b0};
      else if (s_over)                  n0 = {sgn, 8'hff, 23'b0};
      else                              n0 = {sgn, s_ne[7:0], s_fr};
    end else begin
      if (x_e == 15'd0 && x_m == 64'd0) n0 = 32'b0;
      else if (&x_e)                    {n0, n1} = {sgn, 11'h7ff, d_nan};
      else if (x_e == 15'd0 || d_under) n0 = {sgn, 31'b0};
      else if (d_over)                  n0 = {sgn, 11'h7ff, 20'b0};
      else                              {n0, n1} = {sgn, d_ne[10:0], d_fr};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_w0 <= 32'b0; out_w1 <= 32'b0; out_w2 <= 32'b0;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_w0 <= n0; out_w1 <= n1; out_w2 <= n2;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_valid_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  p_hold_on_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_w0) && $stable(out_w1) && $stable(out_w2)));
  p_zero_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_fmt == 2'd0 && in_w0[30:0] == 31'd0) |=> (out_w0 == 32'd0 && out_w1 == 32'd0));
  p_integer_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_fmt == 2'd0 && in_w0[30:23] != 8'd0) |=> out_w1[31]);
  p_sign_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_fmt == 2'd1 && in_w0[30:20] != 11'd0) |=> out_w0[31] == $past(in_w0[31]));
endmodule

// File: tb/fp_ext_converter_test.sv
module fp_ext_converter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [1:0] in_fmt = 2'd0;
  logic [31:0] in_w0 = 0, in_w1 = 0, in_w2 = 0;
  logic in_ready, out_valid;
  logic [31:0] out_w0, out_w1, out_w2;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fp_ext_converter uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_w0(in_w0), .in_w1(in_w1), .in_w2(in_w2), .out_valid(out_valid),
    .out_ready(out_ready), .out_w0(out_w0), .out_w1(out_w1), .out_w2(out_w2));

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [95:0] pack(input bit dbl, input logic s, input int e, input longint unsigned fr);
    if (dbl) return {s, 11'(e), 52'(fr), 32'b0};
    return {s, 8'(e), 23'(fr), 64'b0};
  endfunction

  function automatic void model(input logic [1:0] f, input logic [31:0] a, b, c,
                                output logic [95:0] r, output string tag);
    logic s = a[31];
    bit dbl = f[0];
    int fw = dbl ? 52 : 23;
    int bias = dbl ? 1023 : 127;
    int maxe = dbl ? 2047 : 255;
    int e, ne, drop;
    longint unsigned fr, m, k, rb;
    if (f < 2) begin
      e  = dbl ? int'(a[30:20]) : int'(a[30:23]);
      fr = dbl ? {a[19:0], b} : 64'(a[22:0]);
      m  = (64'd1 << 63) | (fr << (63 - fw));
      if (e == 0 && fr == 0) begin r = '0; tag = "R4"; end
      else if (e == 0) begin r = {s, 95'b0}; tag = "R9"; end
      else if (e == maxe) begin r = {s, 15'h7fff, 16'h0, m}; tag = "R8"; end
      else begin r = {s, 15'(e - bias + 16383), 16'h0, m}; tag = "R5"; end
    end else begin
      m = {b, c};
      e = int'(a[30:16]);
      drop = 64 - (fw + 1);
      if (e == 0 && m == 0) begin r = '0; tag = "R4"; end
      else if (e == 32767) begin
        fr = (m >> drop) & ((64'd1 << fw) - 1);
        if ((m & ((64'd1 << drop) - 1)) != 0) fr = fr | 1;
        r = pack(dbl, s, maxe, fr); tag = "R8";
      end else if (e == 0) begin r = {s, 95'b0}; tag = "R9"; end
      else begin
        rb = (m >> (drop - 1)) & 1;
        k  = (m >> drop) + rb;
        ne = e - 16383 + bias;
        tag = rb != 0 ? "R6" : "R3";
        if ((k >> (fw + 1)) != 0) begin k = k >> 1; ne++; tag = "R7"; end
        if (ne <= 0) begin r = {s, 95'b0}; tag = "R9"; end
        else if (ne >= maxe) begin r = pack(dbl, s, maxe, 0); tag = "R10"; end
        else r = pack(dbl, s, ne, k & ((64'd1 << fw) - 1));
      end
    end
  endfunction

  logic [95:0] q[$];
  string tq[$];
  bit mv = 0, held = 0;

  initial begin
    logic [95:0] r;
    string tag;
    bit fire, acc;
    repeat (3) @(negedge clk);
    check("R1", {94'b0, out_valid, in_ready}, {94'b0, 1'b0, 1'b1});
    rst_n = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      check("R1", {95'b0, in_ready}, {95'b0, !mv || out_ready});
      check("R1", {95'b0, out_valid}, {95'b0, mv});
      if (mv) check(held ? "R2" : tq[0], {out_w0, out_w1, out_w2}, q[0]);
      in_valid = 1'b1; out_ready = 1'b1;
      case (i)
        0: begin in_fmt = 0; in_w0 = 32'h3f800000; end
        1: begin in_fmt = 0; in_w0 = 32'h80000000; end
        2: begin in_fmt = 0; in_w0 = 32'h7f800000; end
        3: begin in_fmt = 0; in_w0 = 32'h80000001; end
        4: begin in_fmt = 1; in_w0 = 32'h3ff00000; in_w1 = 0; end
        5: begin in_fmt = 2; in_w0 = 32'h3fff0000; in_w1 = 32'h80000000; in_w2 = 0; end
        6: begin in_fmt = 2; in_w0 = 32'h3fff0000; in_w1 = 32'hffffff80; in_w2 = 0; end
        7: begin in_fmt = 2; in_w0 = 32'h3fff0000; in_w1 = 32'h80000080; in_w2 = 0; end
        8: begin in_fmt = 3; in_w0 = 32'h7ffe0000; in_w1 = 32'h80000000; in_w2 = 0; end
        9: begin in_fmt = 2; in_w0 = 32'h80010000; in_w1 = 32'h80000000; in_w2 = 0; end
        10: begin in_fmt = 2; in_w0 = 32'h7fff0000; in_w1 = 32'h80000000; in_w2 = 1; end
        11: begin in_fmt = 3; in_w0 = 32'h3fff0000; in_w1 = 32'hffffffff; in_w2 = 32'hfffff800; end
        12: begin in_fmt = 3; in_w0 = 32'hc0000000; in_w1 = 32'hc0000000; in_w2 = 32'h00000400; end
        13, 14, 15: begin out_ready = 1'b0; in_fmt = 1; in_w0 = 32'hc0123456; in_w1 = 32'h789abcde; end
        default: begin
          out_ready = ($urandom % 10) < 7;
          in_valid  = ($urandom % 10) < 8;
          in_fmt = 2'($urandom);
          in_w1 = $urandom; in_w2 = $urandom;
          if (in_fmt[1]) begin
            int span = in_fmt[0] ? 1100 : 140;
            logic [14:0] xe = 15'(16383 - span + int'($urandom % (2 * span)));
            if ($urandom % 16 == 0) xe = 15'h7fff;
            if ($urandom % 16 == 1) xe = 15'h0;
            in_w0 = {1'($urandom), xe, 16'h0};
            if ($urandom % 8 != 0) in_w1[31] = 1'b1;
          end else in_w0 = $urandom;
        end
      endcase
      fire = mv && out_ready;
      acc  = in_valid && (!mv || out_ready);
      held = mv && !out_ready;
      if (fire) begin void'(q.pop_front()); void'(tq.pop_front()); end
      if (acc) begin model(in_fmt, in_w0, in_w1, in_w2, r, tag); q.push_back(r); tq.push_back(tag); end
      mv = acc || (mv && !out_ready);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule